// File: doc/BRIEF.md
# Status and Write-Guard Unit for a Serial Memory

This block holds the status and protection state of a small serial memory of 2^ADDR_W bytes. It keeps a write-permission latch, a write-busy flag, a two-bit protection level and a pin-lock enable bit. A command decoder, which sits outside this block, hands it one decoded command per cycle. The block answers status reads with a formatted byte and applies status-register updates. For every memory write request it decides whether the write may go ahead, and it issues a one-cycle grant or deny pulse.

An accepted write, to the array or to the status register, starts a busy timer that is BUSY_CYCLES long. While the timer runs, status reads return 0xFF and all other commands are dropped. When the timer expires, the permission latch clears itself. The protection level and the pin-lock bit stand in for nonvolatile cells. They survive a soft power-up pulse, which clears the latch and aborts the busy timer. Only the synchronous reset clears everything.

Top module: `spi_stat_guard`

## Requirements
- R1: After `rst`, `busy`, `wr_grant` and `wr_deny` are 0, and a status read returns 0x00.
- R2: A status read (`cmd_op`=3) raises `stat_valid` for one cycle on the clock edge after the request. The byte is laid out as bit7 = pin-lock enable, bits 6:4 = 0, bits 3:2 = protection level, bit1 = permission latch, bit0 = busy.
- R3: `cmd_op`=1 sets the permission latch and `cmd_op`=2 clears it.
- R4: A status write (`cmd_op`=4) with the latch set and no pin lock is granted. It loads bit7 and bits 3:2 from `cmd_data` and ignores the other data bits.
- R5: When pin-lock enable is 1 and `wp_n` is 0, a status write is denied and leaves the status contents and the latch unchanged. When pin-lock enable is 0, `wp_n` has no effect.
- R6: Protection level 0 protects no address, level 1 protects the top quarter of the address space, level 2 the top half, and level 3 all addresses. A memory write (`cmd_op`=5) to a protected address is denied.
- R7: A write requested while the latch is 0 is denied. A denied request pulses `wr_deny` once, starts no busy period and leaves the latch as it was.
- R8: A granted write pulses `wr_grant` once. `busy` is then 1 for exactly BUSY_CYCLES cycles, and the latch reads 0 afterwards.
- R9: A status read while busy returns 0xFF.
- R10: While busy, every command other than a status read is ignored: no pulse and no state change.
- R11: A `pwr_up` pulse clears the latch and ends any busy period. It keeps the pin-lock enable and the protection level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, clears all state |
| pwr_up | input | 1 | Soft power-up pulse, clears the volatile state only |
| cmd_valid | input | 1 | A decoded command is present this cycle |
| cmd_op | input | 3 | 1 set latch, 2 clear latch, 3 status read, 4 status write, 5 memory write |
| cmd_addr | input | ADDR_W | Target byte address of a memory write |
| cmd_data | input | 8 | New status contents for a status write |
| wp_n | input | 1 | Write-protect pin, active low |
| stat_valid | output | 1 | Status byte is valid |
| stat_byte | output | 8 | Formatted status byte |
| wr_grant | output | 1 | Write request accepted |
| wr_deny | output | 1 | Write request refused |
| busy | output | 1 | Write cycle in progress |

## Verification
The hardest cases to reach are the ones where a request arrives while the busy timer is still running, or on the edge where the timer ends. Reaching them needs a granted write first, so the stimulus sets the latch and then issues a write that is known to be allowed. While the busy period runs, the bench injects latch-set, latch-clear, memory-write and status-write commands. The monitor must then see no grant or deny pulse, and a status read after the timer expires shows that the latch cleared regardless of those commands. A power-up pulse is also delivered in the middle of a busy period, to confirm that the period stops at once while the protection bits stay.

// File: rtl/sg_pkg.sv
package sg_pkg;
  typedef enum logic [2:0] {
    OP_NONE      = 3'd0,
    OP_LATCH_SET = 3'd1,
    OP_LATCH_CLR = 3'd2,
    OP_STAT_RD   = 3'd3,
    OP_STAT_WR   = 3'd4,
    OP_MEM_WR    = 3'd5
  } sg_op_e;

  localparam int STAT_W      = 8;
  localparam int BIT_LOCK    = 7;
  localparam int BIT_LVL_HI  = 3;
  localparam int BIT_LVL_LO  = 2;
  localparam int BIT_LATCH   = 1;
  localparam int BIT_BUSY    = 0;
  localparam int LVL_W       = BIT_LVL_HI - BIT_LVL_LO + 1;
endpackage

// File: rtl/sg_prot_decode.sv
module sg_prot_decode #(
  parameter int ADDR_W = 11
) (
  input  logic [ADDR_W-1:0]        addr,
  input  logic [sg_pkg::LVL_W-1:0] level,
  output logic                     hit
);
  localparam int TOP = ADDR_W - 1;

  logic [1:0] quarter;
  assign quarter = addr[TOP -: 2];

  always_comb begin
    unique case (level)
      2'd0:    hit = 1'b0;
      2'd1:    hit = (quarter == 2'b11);
      2'd2:    hit = quarter[1];
      default: hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/sg_busy_timer.sv
module sg_busy_timer #(
  parameter int CYCLES = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;

  assign busy = (cnt_q != '0);
  assign done = (cnt_q == CW'(1)) && !clear;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= CW'(CYCLES);
    end else if (busy) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  // R8: counter never passes its configured length
  a_r8_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(CYCLES));

  // R10: the owner must not restart a running timer
  a_r10_start_idle: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);

  // R8: a finishing count leaves the timer idle
  a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> !busy);
endmodule

// File: rtl/sg_status_view.sv
module sg_status_view (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      rd_req,
  input  logic                      busy,
  input  logic                      lock_en,
  input  logic [sg_pkg::LVL_W-1:0]  level,
  input  logic                      latch,
  output logic                      stat_valid,
  output logic [sg_pkg::STAT_W-1:0] stat_byte
);
  import sg_pkg::*;

  logic [STAT_W-1:0] view;

  always_comb begin
    view = '0;
    if (busy) begin
      view = '1;
    end else begin
      view[BIT_LOCK]               = lock_en;
      view[BIT_LVL_HI:BIT_LVL_LO]  = level;
      view[BIT_LATCH]              = latch;
      view[BIT_BUSY]               = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_valid <= 1'b0;
      stat_byte  <= '0;
    end else begin
      stat_valid <= rd_req;
      if (rd_req) stat_byte <= view;
    end
  end

  // R9: a read issued during a write returns all ones
  a_r9_busy_ones: assert property (@(posedge clk) disable iff (rst)
    (rd_req && busy) |=> (stat_byte == '1));

  // R2: the response lasts exactly one cycle per request
  a_r2_one_shot: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> !stat_valid);
endmodule

// File: rtl/spi_stat_guard.sv
module spi_stat_guard #(
  parameter int ADDR_W      = 11,
  parameter int BUSY_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_up,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_data,
  input  logic              wp_n,
  output logic              stat_valid,
  output logic [7:0]        stat_byte,
  output logic              wr_grant,
  output logic              wr_deny,
  output logic              busy
);
  import sg_pkg::*;

  sg_op_e op;
  assign op = sg_op_e'(cmd_op);

  logic             lock_q;
  logic [LVL_W-1:0] lvl_q;
  logic             latch_q;
  logic             prot_hit;
  logic             tmr_done;

  logic unused_data_bits;
  assign unused_data_bits = ^{cmd_data[6:4], cmd_data[1:0]};

  sg_prot_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr  (cmd_addr),
    .level (lvl_q),
    .hit   (prot_hit)
  );

  logic live_cmd;
  logic is_swr, is_mwr;
  logic stat_ok, mem_ok;
  logic accept, refuse;

  assign live_cmd = cmd_valid && !busy && !pwr_up;
  assign is_swr   = live_cmd && (op == OP_STAT_WR);
  assign is_mwr   = live_cmd && (op == OP_MEM_WR);
  assign stat_ok  = latch_q && !(lock_q && !wp_n);
  assign mem_ok   = latch_q && !prot_hit;
  assign accept   = (is_swr && stat_ok) || (is_mwr && mem_ok);
  assign refuse   = (is_swr && !stat_ok) || (is_mwr && !mem_ok);

  sg_busy_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .clear (pwr_up),
    .start (accept),
    .busy  (busy),
    .done  (tmr_done)
  );

  sg_status_view u_view (
    .clk        (clk),
    .rst        (rst),
    .rd_req     (cmd_valid && (op == OP_STAT_RD)),
    .busy       (busy),
    .lock_en    (lock_q),
    .level      (lvl_q),
    .latch      (latch_q),
    .stat_valid (stat_valid),
    .stat_byte  (stat_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q   <= 1'b0;
      lvl_q    <= '0;
      latch_q  <= 1'b0;
      wr_grant <= 1'b0;
      wr_deny  <= 1'b0;
    end else begin
      wr_grant <= accept;
      wr_deny  <= refuse;
      if (pwr_up || tmr_done) begin
        latch_q <= 1'b0;
      end else if (live_cmd && op == OP_LATCH_SET) begin
        latch_q <= 1'b1;
      end else if (live_cmd && op == OP_LATCH_CLR) begin
        latch_q <= 1'b0;
      end
      if (accept && is_swr) begin
        lock_q <= cmd_data[BIT_LOCK];
        lvl_q  <= cmd_data[BIT_LVL_HI:BIT_LVL_LO];
      end
    end
  end

  // R7: grant and deny never coincide
  a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(wr_grant && wr_deny));

  // R7: a refusal leaves the latch where it was
  a_r7_deny_keeps_latch: assert property (@(posedge clk) disable iff (rst)
    wr_deny |-> (latch_q == $past(latch_q)));

  // R6: a write into a protected range is never granted
  a_r6_protected_refused: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && op == OP_MEM_WR && prot_hit) |=> !wr_grant);

  // R5: pin lock freezes the status contents
  a_r5_lock_holds: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && op == OP_STAT_WR && lock_q && !wp_n) |=> ($stable(lock_q) && $stable(lvl_q)));

  // R8: the latch is clear once a busy period ends
  a_r8_latch_after_busy: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !$past(pwr_up)) |-> !latch_q);

  // R10: requests during a busy period produce no result
  a_r10_no_result_busy: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd_valid && op != OP_STAT_RD) |=> (!wr_grant && !wr_deny));

  // R11: power-up pulse keeps the protection bits
  a_r11_pwr_keeps: assert property (@(posedge clk) disable iff (rst)
    pwr_up |=> ($stable(lock_q) && $stable(lvl_q) && !latch_q && !busy));
endmodule

// File: tb/test_spi_stat_guard.sv
module test_spi_stat_guard;
  localparam int AW = 11;
  localparam int B  = 6;

  logic          clk = 1'b0;
  logic          rst, pwr_up, cmd_valid, wp_n;
  logic [2:0]    cmd_op;
  logic [AW-1:0] cmd_addr;
  logic [7:0]    cmd_data;
  logic          stat_valid, wr_grant, wr_deny, busy;
  logic [7:0]    stat_byte;

  spi_stat_guard #(.ADDR_W(AW), .BUSY_CYCLES(B)) i_spi_stat_guard (
    .clk(clk), .rst(rst), .pwr_up(pwr_up), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data), .wp_n(wp_n),
    .stat_valid(stat_valid), .stat_byte(stat_byte),
    .wr_grant(wr_grant), .wr_deny(wr_deny), .busy(busy)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int edges  = 0;
  always @(posedge clk) edges <= edges + 1;

  // scoreboard item: kind 0 = status byte, 1 = grant, 2 = deny
  typedef struct { int kind; logic [7:0] val; string req; } item_t;
  item_t exp_q[$];

  // reference state kept from the requirements
  logic       m_lock = 0, m_latch = 0;
  logic [1:0] m_lvl = 0;
  int         acc_edge = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic bit protected_addr(input logic [AW-1:0] a, input logic [1:0] lvl);
    case (lvl)
      2'd0: return 1'b0;
      2'd1: return a >= 11'h600;
      2'd2: return a >= 11'h400;
      default: return 1'b1;
    endcase
  endfunction

  // monitor: pops one expected item per observed result
  always @(negedge clk) begin
    if (!rst) begin
      int got;
      got = stat_valid ? 0 : (wr_grant ? 1 : (wr_deny ? 2 : -1));
      if (got >= 0) begin
        if (exp_q.size() == 0) begin
          check(0, "R10 unexpected result", got, -1);
        end else begin
          item_t it;
          it = exp_q.pop_front();
          check(it.kind == got, it.req, got, it.kind);
          if (got == 0) check(stat_byte == it.val, it.req, stat_byte, it.val);
        end
      end
    end
  end

  task automatic cmd(input int op, input logic [AW-1:0] a, input logic [7:0] d, input string req);
    int  e;
    bit  bz;
    item_t it;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'(op); cmd_addr = a; cmd_data = d;
    e = edges + 1;
    if (acc_edge != 0 && e > acc_edge + B) begin m_latch = 0; acc_edge = 0; end
    bz = (acc_edge != 0);
    it.req = req; it.val = 8'h00;
    if (op == 3) begin
      it.kind = 0;
      it.val  = bz ? 8'hFF : {m_lock, 3'b000, m_lvl, m_latch, 1'b0};
      exp_q.push_back(it);
    end else if (!bz) begin
      if (op == 1) m_latch = 1;
      else if (op == 2) m_latch = 0;
      else if (op == 4) begin
        if (m_latch && !(m_lock && !wp_n)) begin
          m_lock = d[7]; m_lvl = d[3:2]; acc_edge = e; it.kind = 1;
        end else it.kind = 2;
        exp_q.push_back(it);
      end else if (op == 5) begin
        if (m_latch && !protected_addr(a, m_lvl)) begin acc_edge = e; it.kind = 1; end
        else it.kind = 2;
        exp_q.push_back(it);
      end
    end
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0;
  endtask

  task automatic busy_run(input string req);
    for (int k = 0; k < B; k++) begin
      check(busy == 1'b1, req, busy, 1);
      @(negedge clk);
    end
    check(busy == 1'b0, req, busy, 0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic soft_power;
    @(negedge clk); pwr_up = 1'b1;
    @(negedge clk); pwr_up = 1'b0;
    m_latch = 0; acc_edge = 0;
    check(busy == 1'b0, "R11 busy cleared", busy, 0);
  endtask

  initial begin
    #(200000 * 10);
    check(0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1; pwr_up = 0; cmd_valid = 0; cmd_op = 0; cmd_addr = 0; cmd_data = 0; wp_n = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    check(busy == 0 && wr_grant == 0 && wr_deny == 0, "R1 reset outputs", busy, 0);
    cmd(3, 0, 0, "R1 R2 reset status");
    cmd(1, 0, 0, "R3 set");
    cmd(3, 0, 0, "R3 latch set read");
    cmd(2, 0, 0, "R3 clear");
    cmd(3, 0, 0, "R3 latch clear read");
    cmd(4, 0, 8'hFF, "R7 status write without latch");
    cmd(3, 0, 0, "R7 nothing changed");
    // granted status write with stray data bits
    cmd(1, 0, 0, "R3 set");
    cmd(4, 0, 8'hFF, "R4 status write granted");
    cmd(3, 0, 0, "R9 read while busy");
    idle(B);
    cmd(3, 0, 0, "R4 R8 ignored bits and latch cleared");
    // pin lock active
    wp_n = 0;
    cmd(1, 0, 0, "R3 set");
    cmd(4, 0, 8'h00, "R5 locked status write");
    cmd(3, 0, 0, "R5 contents and latch kept");
    wp_n = 1;
    cmd(4, 0, 8'h04, "R5 unlocked status write");
    busy_run("R8 busy length");
    // lock disabled: pin no longer matters
    wp_n = 0;
    cmd(1, 0, 0, "R3 set");
    cmd(4, 0, 8'h08, "R5 pin ignored when lock off");
    idle(B + 1);
    wp_n = 1;
    cmd(3, 0, 0, "R5 level 2 loaded");
    // level 2: top half protected
    cmd(1, 0, 0, "R3 set");
    cmd(5, 11'h3FF, 0, "R6 level2 below half granted");
    busy_run("R8 memory write busy length");
    cmd(1, 0, 0, "R3 set");
    cmd(5, 11'h400, 0, "R6 level2 0x400 denied");
    cmd(5, 11'h7FF, 0, "R6 level2 0x7FF denied");
    cmd(3, 0, 0, "R7 latch kept after deny");
    check(busy == 0, "R7 no busy after deny", busy, 0);
    // level 1
    cmd(4, 0, 8'h04, "R4 level 1");
    idle(B + 1);
    cmd(1, 0, 0, "R3 set");
    cmd(5, 11'h5FF, 0, "R6 level1 0x5FF granted");
    idle(B + 1);
    cmd(1, 0, 0, "R3 set");
    cmd(5, 11'h600, 0, "R6 level1 0x600 denied");
    // level 3
    cmd(4, 0, 8'h0C, "R4 level 3");
    idle(B + 1);
    cmd(1, 0, 0, "R3 set");
    cmd(5, 11'h000, 0, "R6 level3 0x000 denied");
    // level 0
    cmd(4, 0, 8'h00, "R4 level 0");
    idle(B + 1);
    cmd(5, 11'h7FF, 0, "R7 memory write without latch");
    cmd(1, 0, 0, "R3 set");
    cmd(5, 11'h7FF, 0, "R6 level0 0x7FF granted");
    // commands during the busy period
    cmd(1, 0, 0, "R10 set ignored");
    cmd(5, 11'h000, 0, "R10 write ignored");
    cmd(4, 0, 8'h8C, "R10 status write ignored");
    cmd(3, 0, 0, "R9 read while busy");
    idle(B);
    cmd(3, 0, 0, "R10 R8 state after busy");
    // soft power-up
    cmd(1, 0, 0, "R3 set");
    cmd(4, 0, 8'h88, "R4 lock and level 2");
    idle(B + 1);
    cmd(1, 0, 0, "R3 set");
    cmd(5, 11'h000, 0, "R11 write before power-up");
    idle(2);
    soft_power();
    cmd(3, 0, 0, "R11 bits kept, latch and busy cleared");
    idle(3);
    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule